// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupts

This block is a memory-mapped bank of 32 general-purpose pins behind a simple 32-bit register bus with word-aligned byte addresses. Each pin has a direction bit and an output latch. Software never writes these two words directly. It writes ones to set or clear aliases, so concurrent software agents can change single pins without a read-modify-write. Every pin input passes through a two-flop synchroniser and can be read back.

The low quarter of the bank (pins 7:0 by default) can raise interrupts. One packed control word holds four 8-bit per-pin fields: rise enable, fall enable, debounce enable and level mode. This word is also changed only through set and clear aliases.

In edge mode the rise and fall bits choose which transitions latch a pending bit. A latched bit stays set until software writes a one to the clear address. In level mode the same two bits select active-high or active-low triggering, and the pending bit follows the qualified level. When the debounce bit is set, a change at the input is accepted only after it has held for a parameterised number of cycles. A single combined interrupt line is the OR of the pending bits of unmasked pins.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all pins are inputs (pin_oe = 0), the output latch and the interrupt control word are zero, no interrupt is pending and irq_out is low.
- R2: A write to byte address 0x04 makes the pins at one bits outputs, and a write to 0x08 makes them inputs. Zero bits leave a pin's direction unchanged. Address 0x00 reads the direction word (1 = output), and pin_oe equals that word from the cycle after the write.
- R3: A write to 0x10 sets the output latch bits at one bits, and a write to 0x14 clears them. Zero bits are ignored. Reading 0x10 returns the latch, and pin_out equals it.
- R4: The interrupt control word is set at one bits by a write to 0x18, cleared at one bits by a write to 0x1C, and read at 0x18. Its fields are rise/high enable in bits 7:0, fall/low enable in bits 15:8, debounce enable in bits 23:16 and level mode in bits 31:24, bit n of each field belonging to pin n.
- R5: With level mode clear, a rising input latches the pin's pending bit if its rise bit is set. A falling input latches it if its fall bit is set. With both bits set, both edges latch it, and a pulse of a single cycle is caught.
- R6: With level mode set, the rise bit makes a high input active and the fall bit makes a low input active. The pending bit follows the active condition. A clear write removes it for one cycle, after which it returns while the level is still active, and it drops when the level goes inactive.
- R7: A write to 0x20 clears the latched edge pending bits at one bits and leaves the others. An edge detected in the same cycle as the clear of that pin wins, and the bit stays set.
- R8: Reading 0x24 returns the pending bits in 7:0 and zero in bits 31:8. Pins 31:8 never cause an interrupt.
- R9: irq_out is the OR of the pending bits of pins whose rise or fall bit is set. Clearing both bits of a pin masks it from irq_out while its pending bit stays readable.
- R10: Reading 0x0C returns pin_in delayed by two clock edges through the synchroniser.
- R11: With a pin's debounce bit set, a change is accepted only after the synchronised input has differed from the accepted value for DEB_CYCLES consecutive edges. A pulse of DEB_CYCLES-1 cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Read data, combinational from the current address |
| pin_in | input | N_PINS | Asynchronous pin inputs |
| pin_out | output | N_PINS | Output latch to the pad drivers |
| pin_oe | output | N_PINS | Output enable per pin (1 = drive) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two functions can land on the same clock edge: a clear written to 0x20 and a fresh edge detected on the same pin. The bench first latches a pending bit on a pin armed for both edges. It then toggles that pin and times the clear write to hit the edge at which the synchronised transition is detected. A pending bit that still reads one afterwards shows the new event was kept. The same kind of clear on a level-mode pin is judged the opposite way: status must read zero right after the write and one a cycle later.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [7:0] {
    OFS_DIR       = 8'h00,
    OFS_DIR_OUT   = 8'h04,
    OFS_DIR_IN    = 8'h08,
    OFS_PIN       = 8'h0C,
    OFS_OUT_SET   = 8'h10,
    OFS_OUT_CLR   = 8'h14,
    OFS_ICTL_SET  = 8'h18,
    OFS_ICTL_CLR  = 8'h1C,
    OFS_IPEND_CLR = 8'h20,
    OFS_IPEND     = 8'h24
  } gpio_ofs_e;

  // Index of each per-pin field inside the packed interrupt control word
  localparam int FLD_RISE = 0;
  localparam int FLD_FALL = 1;
  localparam int FLD_DEB  = 2;
  localparam int FLD_LVL  = 3;
  localparam int FLD_NUM  = 4;

  // Edge qualifier: a transition of the effective input that is enabled
  function automatic logic f_edge_hit(input logic cur, input logic prev,
                                      input logic rise_en, input logic fall_en);
    return (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
  endfunction

  // Level qualifier: rise field selects active-high, fall field active-low
  function automatic logic f_level_hit(input logic cur,
                                       input logic hi_en, input logic lo_en);
    return (hi_en & cur) | (lo_en & ~cur);
  endfunction

  // Next pending state: an edge event beats a clear, a level clear wins for one cycle
  function automatic logic f_pend_next(input logic pend, input logic clr,
                                       input logic hit, input logic lvl);
    logic nxt;
    if (lvl) nxt = hit & ~clr;
    else     nxt = (pend & ~clr) | hit;
    return nxt;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differs;
  logic             accept;

  assign differs = din ^ filt_q;
  assign accept  = en & differs & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en) begin
      filt_q <= din;
      cnt_q  <= '0;
    end else if (!differs) begin
      cnt_q  <= '0;
    end else if (accept) begin
      filt_q <= din;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign dout = en ? filt_q : din;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic eff_in,
  input  logic rise_en,
  input  logic fall_en,
  input  logic lvl_en,
  input  logic clr,
  output logic hit,
  output logic pend
);
  logic prev_q;
  logic pend_q;

  always_comb begin
    if (lvl_en) hit = f_level_hit(eff_in, rise_en, fall_en);
    else        hit = f_edge_hit(eff_in, prev_q, rise_en, fall_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= eff_in;
      pend_q <= f_pend_next(pend_q, clr, hit, lvl_en);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int N_PINS     = 32,
  parameter int ADDR_W     = 6,
  parameter int DEB_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq_out
);
  localparam int IRQ_PINS = N_PINS / FLD_NUM;

  // Set/clear merge on a whole word
  function automatic logic [N_PINS-1:0] f_set_clr(input logic [N_PINS-1:0] cur,
                                                 input logic [N_PINS-1:0] set_m,
                                                 input logic [N_PINS-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  function automatic logic f_at(input logic [ADDR_W-1:0] a, input gpio_ofs_e o);
    return a == ADDR_W'(o);
  endfunction

  logic              wr_en;
  logic              wr_dir_out, wr_dir_in, wr_out_set, wr_out_clr;
  logic              wr_ictl_set, wr_ictl_clr, wr_ipend_clr;
  logic [N_PINS-1:0] dir_q, out_q, ictl_q;
  logic [N_PINS-1:0] pin_sync;
  logic [IRQ_PINS-1:0] rise_f, fall_f, deb_f, lvl_f;
  logic [IRQ_PINS-1:0] eff_in, irq_hit, irq_pend, pend_clr, irq_live;

  assign wr_en        = bus_sel & bus_wr;
  assign wr_dir_out   = wr_en & f_at(bus_addr, OFS_DIR_OUT);
  assign wr_dir_in    = wr_en & f_at(bus_addr, OFS_DIR_IN);
  assign wr_out_set   = wr_en & f_at(bus_addr, OFS_OUT_SET);
  assign wr_out_clr   = wr_en & f_at(bus_addr, OFS_OUT_CLR);
  assign wr_ictl_set  = wr_en & f_at(bus_addr, OFS_ICTL_SET);
  assign wr_ictl_clr  = wr_en & f_at(bus_addr, OFS_ICTL_CLR);
  assign wr_ipend_clr = wr_en & f_at(bus_addr, OFS_IPEND_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ictl_q <= '0;
    end else begin
      dir_q  <= f_set_clr(dir_q, wr_dir_out ? bus_wdata : '0,
                          wr_dir_in ? bus_wdata : '0);
      out_q  <= f_set_clr(out_q, wr_out_set ? bus_wdata : '0,
                          wr_out_clr ? bus_wdata : '0);
      ictl_q <= f_set_clr(ictl_q, wr_ictl_set ? bus_wdata : '0,
                          wr_ictl_clr ? bus_wdata : '0);
    end
  end

  assign rise_f   = ictl_q[FLD_RISE*IRQ_PINS +: IRQ_PINS];
  assign fall_f   = ictl_q[FLD_FALL*IRQ_PINS +: IRQ_PINS];
  assign deb_f    = ictl_q[FLD_DEB*IRQ_PINS  +: IRQ_PINS];
  assign lvl_f    = ictl_q[FLD_LVL*IRQ_PINS  +: IRQ_PINS];
  assign pend_clr = wr_ipend_clr ? bus_wdata[IRQ_PINS-1:0] : '0;

  gpio_sync2 #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar i = 0; i < IRQ_PINS; i++) begin : g_irq
    gpio_debounce #(.CYCLES(DEB_CYCLES)) u_deb (
      .clk(clk), .rst_n(rst_n), .en(deb_f[i]), .din(pin_sync[i]), .dout(eff_in[i])
    );
    gpio_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n), .eff_in(eff_in[i]),
      .rise_en(rise_f[i]), .fall_en(fall_f[i]), .lvl_en(lvl_f[i]),
      .clr(pend_clr[i]), .hit(irq_hit[i]), .pend(irq_pend[i])
    );
  end

  assign irq_live = irq_pend & (rise_f | fall_f);
  assign irq_out  = |irq_live;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (f_at(bus_addr, OFS_DIR))      bus_rdata = dir_q;
      if (f_at(bus_addr, OFS_PIN))      bus_rdata = pin_sync;
      if (f_at(bus_addr, OFS_OUT_SET))  bus_rdata = out_q;
      if (f_at(bus_addr, OFS_ICTL_SET)) bus_rdata = ictl_q;
      if (f_at(bus_addr, OFS_IPEND))    bus_rdata = {{(N_PINS-IRQ_PINS){1'b0}}, irq_pend};
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_sel,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [N_PINS-1:0]        bus_wdata,
  input logic [N_PINS-1:0]        bus_rdata,
  input logic [N_PINS-1:0]        pin_out,
  input logic [N_PINS-1:0]        pin_oe,
  input logic                     irq_out,
  input logic [N_PINS/FLD_NUM-1:0] pend,
  input logic [N_PINS-1:0]        ictl
);
  localparam int IP = N_PINS / FLD_NUM;

  logic         any_wr;
  logic [IP-1:0] enab, lvl;
  assign any_wr = bus_sel & bus_wr;
  assign enab   = ictl[FLD_RISE*IP +: IP] | ictl[FLD_FALL*IP +: IP];
  assign lvl    = ictl[FLD_LVL*IP +: IP];

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0 && !irq_out && pend == '0));

  a_r2_dir_to_out: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && bus_addr == ADDR_W'(OFS_DIR_OUT)) |=> pin_oe == ($past(pin_oe) | $past(bus_wdata)));

  a_r2_dir_to_in: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && bus_addr == ADDR_W'(OFS_DIR_IN)) |=> pin_oe == ($past(pin_oe) & ~$past(bus_wdata)));

  a_r3_out_set: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && bus_addr == ADDR_W'(OFS_OUT_SET)) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

  a_r3_out_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && bus_addr == ADDR_W'(OFS_OUT_CLR)) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

  a_r6_level_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && bus_addr == ADDR_W'(OFS_IPEND_CLR)) |=>
      (pend & $past(bus_wdata[IP-1:0]) & $past(lvl)) == '0);

  a_r7_edge_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> (($past(pend) & ~$past(lvl)) & ~pend) == '0);

  a_r8_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_IPEND)) |->
      bus_rdata[N_PINS-1:IP] == '0);

  a_r9_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (enab == '0) |-> !irq_out);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out),
  .pend(irq_pend), .ictl(ictl_q)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 4;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  gpio_irq_bank #(.N_PINS(32), .ADDR_W(AW), .DEB_CYCLES(DEB)) i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // Bench's own set/clear model, bit by bit
  function automatic logic [31:0] m_merge(input logic [31:0] cur, input logic [31:0] s,
                                         input logic [31:0] c);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) begin
      if (c[b])      r[b] = 1'b0;
      else if (s[b]) r[b] = 1'b1;
      else           r[b] = cur[b];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write takes effect at the next rising edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[AW-1:0];
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] rd, m_dir, m_out, m_ictl, pv, old;

  initial begin
    m_dir = '0; m_out = '0; m_ictl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(8'h00, rd); check("R1 dir", rd, 32'h0);
    bus_read(8'h10, rd); check("R1 out", rd, 32'h0);
    bus_read(8'h18, rd); check("R1 ictl", rd, 32'h0);
    bus_read(8'h24, rd); check("R1 status", rd, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    check("R1 oe", pin_oe, 32'h0);

    // R2 R3 R4 constrained random alias traffic
    pv = $urandom(32'h5EED_0042);
    for (int k = 0; k < 120; k++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 5);
      d  = $urandom;
      case (op)
        0: begin bus_write(8'h04, d); m_dir  = m_merge(m_dir, d, 0);  bus_read(8'h00, rd); check("R2 dir set", rd, m_dir); check("R2 pin_oe", pin_oe, m_dir); end
        1: begin bus_write(8'h08, d); m_dir  = m_merge(m_dir, 0, d);  bus_read(8'h00, rd); check("R2 dir clr", rd, m_dir); check("R2 pin_oe", pin_oe, m_dir); end
        2: begin bus_write(8'h10, d); m_out  = m_merge(m_out, d, 0);  bus_read(8'h10, rd); check("R3 out set", rd, m_out); check("R3 pin_out", pin_out, m_out); end
        3: begin bus_write(8'h14, d); m_out  = m_merge(m_out, 0, d);  bus_read(8'h10, rd); check("R3 out clr", rd, m_out); check("R3 pin_out", pin_out, m_out); end
        4: begin bus_write(8'h18, d); m_ictl = m_merge(m_ictl, d, 0); bus_read(8'h18, rd); check("R4 ictl set", rd, m_ictl); end
        default: begin bus_write(8'h1C, d); m_ictl = m_merge(m_ictl, 0, d); bus_read(8'h18, rd); check("R4 ictl clr", rd, m_ictl); end
      endcase
    end
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_read(8'h24, rd); check("R7 cleanup status", rd, 32'h0);

    // R10 synchroniser latency
    old = pin_in;
    pv = $urandom;
    pin_in = pv;
    @(negedge clk);
    bus_read(8'h0C, rd); check("R10 one edge old", rd, old);
    @(negedge clk);
    bus_read(8'h0C, rd); check("R10 two edges new", rd, pv);
    pin_in = '0;
    wait_cyc(4);

    // R5 R7 edge mode
    bus_write(8'h18, 32'h0000_0009);
    pin_in = 32'h09; wait_cyc(4);
    bus_read(8'h24, rd); check("R5 rise pins 0,3", rd, 32'h09);
    check("R9 irq high", {31'b0, irq_out}, 32'h1);
    bus_write(8'h20, 32'h01);
    bus_read(8'h24, rd); check("R7 partial clear", rd, 32'h08);
    bus_write(8'h20, 32'h08);
    bus_read(8'h24, rd); check("R7 clear rest, no reassert", rd, 32'h0);
    pin_in = '0; wait_cyc(4);
    bus_read(8'h24, rd); check("R5 fall ignored w/o fall bit", rd, 32'h0);

    bus_write(8'h18, 32'h0000_0200);
    pin_in = 32'h02; wait_cyc(4);
    bus_read(8'h24, rd); check("R5 rise ignored w/o rise bit", rd, 32'h0);
    pin_in = 32'h00; wait_cyc(4);
    bus_read(8'h24, rd); check("R5 fall pin1", rd, 32'h02);
    bus_write(8'h20, 32'h02);

    bus_write(8'h18, 32'h0000_1010);
    pin_in = 32'h10; wait_cyc(4);
    bus_read(8'h24, rd); check("R5 both: rise", rd, 32'h10);
    bus_write(8'h20, 32'h10);
    pin_in = 32'h00; wait_cyc(4);
    bus_read(8'h24, rd); check("R5 both: fall", rd, 32'h10);
    bus_write(8'h20, 32'h10);

    pin_in = 32'h01; @(negedge clk); pin_in = 32'h00; wait_cyc(4);
    bus_read(8'h24, rd); check("R5 one-cycle pulse", rd, 32'h01);
    bus_write(8'h20, 32'h01);

    // R7 collision: falling edge detected on the edge where the clear lands
    pin_in = 32'h10; wait_cyc(4);
    bus_read(8'h24, rd); check("R7 setup pending", rd, 32'h10);
    pin_in = 32'h00;
    @(negedge clk); @(negedge clk);
    bus_write(8'h20, 32'h10);
    bus_read(8'h24, rd); check("R7 event wins over clear", rd, 32'h10);
    bus_write(8'h20, 32'h10);
    bus_read(8'h24, rd); check("R7 later clear", rd, 32'h0);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    wait_cyc(2);

    // R6 level mode
    bus_write(8'h18, 32'h0100_0001);
    wait_cyc(3);
    bus_read(8'h24, rd); check("R6 high level inactive", rd, 32'h0);
    pin_in = 32'h01; wait_cyc(4);
    bus_read(8'h24, rd); check("R6 high level active", rd, 32'h01);
    check("R6 irq", {31'b0, irq_out}, 32'h1);
    bus_write(8'h20, 32'h01);
    bus_read(8'h24, rd); check("R6 cleared one cycle", rd, 32'h0);
    @(negedge clk);
    bus_read(8'h24, rd); check("R6 reasserts", rd, 32'h01);
    pin_in = 32'h00; wait_cyc(4);
    bus_read(8'h24, rd); check("R6 follows level down", rd, 32'h0);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_write(8'h18, 32'h0400_0400);
    wait_cyc(2);
    bus_read(8'h24, rd); check("R6 low level active", rd, 32'h04);
    pin_in = 32'h04; wait_cyc(4);
    bus_read(8'h24, rd); check("R6 low level released", rd, 32'h0);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    pin_in = 32'h00; wait_cyc(4);

    // R9 masking
    bus_write(8'h18, 32'h0000_0020);
    pin_in = 32'h20; wait_cyc(4);
    check("R9 irq before mask", {31'b0, irq_out}, 32'h1);
    bus_write(8'h1C, 32'h0000_0020);
    bus_read(8'h24, rd); check("R9 pending kept while masked", rd, 32'h20);
    check("R9 masked irq low", {31'b0, irq_out}, 32'h0);
    bus_write(8'h18, 32'h0000_0020);
    check("R9 unmask irq", {31'b0, irq_out}, 32'h1);
    bus_write(8'h20, 32'h20);
    check("R9 irq after clear", {31'b0, irq_out}, 32'h0);
    pin_in = 32'h00; wait_cyc(4);
    bus_write(8'h1C, 32'hFFFF_FFFF);

    // R8 upper pins never interrupt
    bus_write(8'h18, 32'h0000_FFFF);
    for (int k = 0; k < 4; k++) begin
      pin_in = {$urandom_range(1, 32'h00FF_FFFF), 8'h00} | 32'h8000_0000;
      wait_cyc(4);
      bus_read(8'h24, rd); check("R8 upper pins silent", rd, 32'h0);
      check("R8 irq low", {31'b0, irq_out}, 32'h0);
      pin_in = '0;
      wait_cyc(4);
    end
    bus_write(8'h1C, 32'hFFFF_FFFF);

    // R11 debounce on pin1
    bus_write(8'h18, 32'h0002_0002);
    pin_in = 32'h02; repeat (DEB - 1) @(negedge clk); pin_in = 32'h00;
    wait_cyc(12);
    bus_read(8'h24, rd); check("R11 short pulse ignored", rd, 32'h0);
    pin_in = 32'h02;
    wait_cyc(DEB + 1);
    bus_read(8'h24, rd); check("R11 not yet accepted", rd, 32'h0);
    wait_cyc(2);
    bus_read(8'h24, rd); check("R11 accepted after hold", rd, 32'h02);
    bus_write(8'h20, 32'h02);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    pin_in = '0;
    wait_cyc(4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule